// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Step Stop Period

This block turns parallel characters into an asynchronous serial stream. A character written into a one-deep holding register moves to a shift register as soon as the shifter is free. It is then sent as a low start bit, followed by 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period. All bit timing comes from a one-cycle clock enable that runs at sixteen times the bit rate. Baud generation is done elsewhere.

The stop period is set in sixteenths of a bit time by a 4-bit code. When 5-bit characters are selected, the short codes follow a separate, longer table. The sender can be held off by a clear-to-send input, and it can drop its request-to-send output by itself once everything has been sent. Command pulses turn the transmitter on and off. Two flags report its state: a ready flag when the holding register is free, and an empty flag when the holding register is free and the shifter is idle.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd`=1, `tx_rdy`=0, `tx_emt`=1 and `rts_o`=0. The line idles high. The start bit is low. Each start, data and parity bit lasts exactly 16 `tick_16x` pulses, and `txd` changes only on a cycle with `tick_16x` high, except when a character starts.
- R2: `cfg_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent from bit 0 upward, and written bits above the selected length are never sent.
- R3: `cfg_par_mode` selects the parity bit. With 00 the bit is computed: with `cfg_par_odd`=0 it makes the count of ones in data plus parity even, and with 1 it makes the count odd. With 01 the parity bit equals `cfg_par_odd`. With 10 or 11 no parity bit is sent.
- R4: The stop period is high and lasts the number of ticks given by `cfg_stop_code` (c). For c in 0..7 it is 9+c ticks, and for c in 8..15 it is 17+c ticks.
- R5: With `cfg_len`=00, codes 0..7 give 17+c ticks. Codes 8..15 are unchanged.
- R6: A held character starts on the clock in which the previous stop period ends, with no idle cycle. `tx_rdy` is high exactly while the transmitter is on and the holding register is free. The holding register frees on the clock after the shifter takes the character.
- R7: `tx_emt` is high exactly while no character is held and the shifter is idle. While it is high, `txd` is high.
- R8: A write while the transmitter is off is ignored. A write while a character is already held is ignored and does not change the held character.
- R9: After `cmd_tx_off`, the character in progress and any held character are still sent in full. Then the line stays high.
- R10: With `cfg_cts_gate`=1 and `cts_ok`=0, no new character starts. A character already started finishes unchanged.
- R11: `cmd_rts_on` sets `rts_o` and `cmd_rts_off` clears it. With `cfg_rts_auto`=1, `rts_o` clears one clock after `tx_emt` rises. With `cfg_rts_auto`=0 it stays set.
- R12: `cmd_tx_on` turns the transmitter on and `cmd_tx_off` turns it off. When both are pulsed in the same cycle, the transmitter is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_16x | input | 1 | Enable at 16 times the bit rate |
| cfg_len | input | 2 | Character length code |
| cfg_par_mode | input | 2 | Parity mode code |
| cfg_par_odd | input | 1 | Parity sense, or the forced value |
| cfg_stop_code | input | 4 | Stop period code |
| cfg_cts_gate | input | 1 | Wait for `cts_ok` before starting a character |
| cfg_rts_auto | input | 1 | Drop `rts_o` when the transmitter becomes empty |
| cts_ok | input | 1 | Clear-to-send, active high |
| cmd_tx_on | input | 1 | Pulse that turns the transmitter on |
| cmd_tx_off | input | 1 | Pulse that turns the transmitter off |
| cmd_rts_on | input | 1 | Pulse that sets `rts_o` |
| cmd_rts_off | input | 1 | Pulse that clears `rts_o` |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emt | output | 1 | Nothing held and the shifter is idle |
| rts_o | output | 1 | Request-to-send, active high |

## Verification
A write strobed in cycle n is taken at the edge that ends cycle n. If the shifter is idle, the start bit appears one clock later, and `tx_rdy` is high again in that same cycle. Each bit then spans 16 ticks. The stop period spans its own tick count, and `tx_emt` rises at the edge where it ends. `rts_o` drops one clock after that. The bench samples on falling clock edges. It anchors each frame on the first sample where the line is low and samples each bit at mid-bit. It counts stop samples until either the next start bit or `tx_emt`. Each expected flag is checked in the sample where the counted edges make it due. One test slows the tick to every third clock, so that the start-bit length shows phase slack while the rest of the frame stays tick-exact.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int CHAR_MAX = 8;
  localparam int OVS      = 16;
  localparam int STOP_MAX = 2 * OVS;
  localparam int CNT_W    = $clog2(STOP_MAX) + 1;
  localparam int LEN_W    = $clog2(CHAR_MAX) + 1;
  localparam int IDX_W    = $clog2(CHAR_MAX);

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_START,
    SH_DATA,
    SH_PAR,
    SH_STOP
  } sh_state_t;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] pmode;
    logic       odd;
    logic [3:0] stop;
  } frame_cfg_t;

  // number of data bits for a length code
  function automatic logic [LEN_W-1:0] char_bits(input logic [1:0] code);
    return LEN_W'(5) + LEN_W'(code);
  endfunction

  // stop period in ticks; codes are in sixteenths of a bit
  function automatic logic [CNT_W-1:0] stop_ticks(input logic [3:0] code,
                                                  input logic       five);
    int unsigned sx;
    if (code[3]) sx = 32'd17 + 32'(code);
    else         sx = 32'd9 + 32'(code) + (five ? 32'd8 : 32'd0);
    return CNT_W'((sx * OVS) / 16);
  endfunction

  function automatic logic par_on(input logic [1:0] pmode);
    return (pmode[1] == 1'b0);
  endfunction

  // parity bit: computed (even/odd) or forced to the sense bit
  function automatic logic par_value(input logic [CHAR_MAX-1:0] d,
                                     input logic [1:0] len,
                                     input logic [1:0] pmode,
                                     input logic       odd);
    logic x;
    x = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++)
      if (i < 5 + int'(len)) x = x ^ d[i];
    if (pmode == 2'b01) return odd;
    return x ^ odd;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_on,
  input  logic                cmd_off,
  input  logic                wr_valid,
  input  logic [CHAR_MAX-1:0] wr_data,
  input  logic                load,
  output logic                hold_full,
  output logic [CHAR_MAX-1:0] hold_data,
  output logic                tx_rdy
);

  logic en_q;
  logic full_q;
  logic [CHAR_MAX-1:0] data_q;
  logic wr_take;

  assign wr_take = wr_valid & en_q & ~full_q;

  // R12: off wins over on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (cmd_off) en_q <= 1'b0;
    else if (cmd_on)  en_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load)    full_q <= 1'b0;
      if (wr_take) begin
        full_q <= 1'b1;
        data_q <= wr_data;
      end
    end
  end

  assign hold_full = full_q;
  assign hold_data = data_q;
  assign tx_rdy    = en_q & ~full_q;

  p_off_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !full_q) |=> !full_q);

  p_held_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !load) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  frame_cfg_t          cfg,
  input  logic                hold_full,
  input  logic [CHAR_MAX-1:0] hold_data,
  input  logic                may_start,
  output logic                load,
  output logic                idle,
  output logic                txd
);

  sh_state_t           state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [IDX_W-1:0]    idx_q;
  logic [CHAR_MAX-1:0] shreg_q;
  logic [LEN_W-1:0]    nbits_q;
  logic                par_en_q;
  logic                par_q;
  logic [CNT_W-1:0]    stop_q;

  logic bit_end;
  logic stop_end;
  logic last_bit;

  assign bit_end  = (cnt_q == CNT_W'(OVS - 1));
  assign stop_end = (state_q == SH_STOP) && tick && (cnt_q == stop_q - CNT_W'(1));
  assign last_bit = ((LEN_W'(idx_q) + LEN_W'(1)) == nbits_q);
  assign idle     = (state_q == SH_IDLE);
  assign load     = hold_full & may_start & (idle | stop_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SH_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      shreg_q  <= '0;
      nbits_q  <= LEN_W'(CHAR_MAX);
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
      stop_q   <= CNT_W'(OVS);
    end else if (load) begin
      state_q  <= SH_START;
      cnt_q    <= '0;
      idx_q    <= '0;
      shreg_q  <= hold_data;
      nbits_q  <= char_bits(cfg.len);
      par_en_q <= par_on(cfg.pmode);
      par_q    <= par_value(hold_data, cfg.len, cfg.pmode, cfg.odd);
      stop_q   <= stop_ticks(cfg.stop, cfg.len == 2'b00);
    end else if (tick) begin
      case (state_q)
        SH_START: begin
          if (bit_end) begin
            state_q <= SH_DATA;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        SH_DATA: begin
          if (bit_end) begin
            cnt_q   <= '0;
            shreg_q <= shreg_q >> 1;
            if (last_bit) state_q <= par_en_q ? SH_PAR : SH_STOP;
            else          idx_q   <= idx_q + IDX_W'(1);
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        SH_PAR: begin
          if (bit_end) begin
            state_q <= SH_STOP;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        SH_STOP: begin
          if (stop_end) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      SH_START: txd = 1'b0;
      SH_DATA:  txd = shreg_q[0];
      SH_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  p_line_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !tick) |=> $stable(txd));

  p_load_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> hold_full);

endmodule

// File: rtl/sertx_rts.sv
module sertx_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic auto_drop,
  input  logic tx_emt,
  output logic rts_o
);

  logic emt_d;
  logic rts_q;
  logic emt_rise;

  assign emt_rise = tx_emt & ~emt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emt_d <= 1'b1;
      rts_q <= 1'b0;
    end else begin
      emt_d <= tx_emt;
      if (clr_req || (auto_drop && emt_rise)) rts_q <= 1'b0;
      else if (set_req)                       rts_q <= 1'b1;
    end
  end

  assign rts_o = rts_q;

  p_rts_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_drop && $rose(tx_emt)) |=> !rts_o);

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par_mode,
  input  logic       cfg_par_odd,
  input  logic [3:0] cfg_stop_code,
  input  logic       cfg_cts_gate,
  input  logic       cfg_rts_auto,
  input  logic       cts_ok,
  input  logic       cmd_tx_on,
  input  logic       cmd_tx_off,
  input  logic       cmd_rts_on,
  input  logic       cmd_rts_off,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_emt,
  output logic       rts_o
);

  frame_cfg_t          cfg;
  logic                load;
  logic                sh_idle;
  logic                hold_full;
  logic [CHAR_MAX-1:0] hold_data;
  logic                may_start;

  assign cfg.len   = cfg_len;
  assign cfg.pmode = cfg_par_mode;
  assign cfg.odd   = cfg_par_odd;
  assign cfg.stop  = cfg_stop_code;

  assign may_start = ~cfg_cts_gate | cts_ok;

  sertx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_on    (cmd_tx_on),
    .cmd_off   (cmd_tx_off),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .load      (load),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .tx_rdy    (tx_rdy)
  );

  sertx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_16x),
    .cfg       (cfg),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .may_start (may_start),
    .load      (load),
    .idle      (sh_idle),
    .txd       (txd)
  );

  assign tx_emt = ~hold_full & sh_idle;

  sertx_rts u_rts (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (cmd_rts_on),
    .clr_req   (cmd_rts_off),
    .auto_drop (cfg_rts_auto),
    .tx_emt    (tx_emt),
    .rts_o     (rts_o)
  );

  p_empty_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_emt |-> txd);

  p_cts_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_cts_gate) |-> cts_ok);

endmodule

// File: tb/sertx_core_tb_top.sv
`timescale 1ns/1ps
module sertx_core_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_16x = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic [1:0] cfg_par_mode = 2'b10;
  logic cfg_par_odd = 1'b0;
  logic [3:0] cfg_stop_code = 4'd7;
  logic cfg_cts_gate = 1'b0;
  logic cfg_rts_auto = 1'b0;
  logic cts_ok = 1'b1;
  logic cmd_tx_on = 1'b0, cmd_tx_off = 1'b0, cmd_rts_on = 1'b0, cmd_rts_off = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, tx_rdy, tx_emt, rts_o;

  int checks = 0;
  int errors = 0;
  int tp = 1;
  int tk = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tp <= 1) tick_16x <= 1'b1;
    else begin
      tk = (tk + 1) % tp;
      tick_16x <= (tk == 0);
    end
  end

  sertx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .cfg_len(cfg_len),
    .cfg_par_mode(cfg_par_mode), .cfg_par_odd(cfg_par_odd),
    .cfg_stop_code(cfg_stop_code), .cfg_cts_gate(cfg_cts_gate),
    .cfg_rts_auto(cfg_rts_auto), .cts_ok(cts_ok), .cmd_tx_on(cmd_tx_on),
    .cmd_tx_off(cmd_tx_off), .cmd_rts_on(cmd_rts_on), .cmd_rts_off(cmd_rts_off),
    .wr_valid(wr_valid), .wr_data(wr_data), .txd(txd), .tx_rdy(tx_rdy),
    .tx_emt(tx_emt), .rts_o(rts_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: cmd_tx_on = 1'b1;
      1: cmd_tx_off = 1'b1;
      2: cmd_rts_on = 1'b1;
      default: cmd_rts_off = 1'b1;
    endcase
    @(negedge clk);
    cmd_tx_on = 1'b0; cmd_tx_off = 1'b0; cmd_rts_on = 1'b0; cmd_rts_off = 1'b0;
  endtask

  function automatic int exp_stop();
    int c = int'(cfg_stop_code);
    if (c >= 8) return 17 + c;
    return (cfg_len == 2'b00) ? 17 + c : 9 + c;
  endfunction

  // receive one frame at tick period 1 and compare against the config
  task automatic frame(input logic [7:0] d, input string tag);
    int guard = 0;
    int nb = 5 + int'(cfg_len);
    int ones = 0;
    int pexp;
    int n = 0;
    while (txd !== 1'b0 && guard < 3000) begin @(negedge clk); guard++; end
    chk(txd === 1'b0, {tag, " R1 start seen"}, int'(txd), 0);
    repeat (8) @(negedge clk);
    chk(txd === 1'b0, {tag, " R1 start mid"}, int'(txd), 0);
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      chk(txd === d[i], {tag, " R2 data bit"}, int'(txd), int'(d[i]));
      if (d[i]) ones++;
    end
    if (!cfg_par_mode[1]) begin
      if (cfg_par_mode == 2'b01) pexp = int'(cfg_par_odd);
      else pexp = cfg_par_odd ? 1 - (ones % 2) : (ones % 2);
      repeat (16) @(negedge clk);
      chk(txd === 1'(pexp), {tag, " R3 parity"}, int'(txd), pexp);
    end
    repeat (8) @(negedge clk);
    while (txd === 1'b1 && tx_emt === 1'b0 && n < 100) begin n++; @(negedge clk); end
    chk(n == exp_stop(), {tag, " R4/R5 stop ticks"}, n, exp_stop());
  endtask

  task automatic set_fmt(input logic [1:0] l, input logic [1:0] pm, input logic od,
                         input logic [3:0] sc);
    cfg_len = l; cfg_par_mode = pm; cfg_par_odd = od; cfg_stop_code = sc;
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
    chk(tx_rdy === 1'b0, "R1 reset tx_rdy", int'(tx_rdy), 0);
    chk(tx_emt === 1'b1, "R1 reset tx_emt", int'(tx_emt), 1);
    chk(rts_o === 1'b0, "R1 reset rts_o", int'(rts_o), 0);
  endtask

  task automatic t_enable_cmds();
    cmd_tx_on = 1'b1; cmd_tx_off = 1'b1;
    @(negedge clk);
    cmd_tx_on = 1'b0; cmd_tx_off = 1'b0;
    chk(tx_rdy === 1'b0, "R12 off wins", int'(tx_rdy), 0);
    pulse(0);
    chk(tx_rdy === 1'b1, "R12 on", int'(tx_rdy), 1);
  endtask

  task automatic t_formats();
    set_fmt(2'b11, 2'b10, 1'b0, 4'd7);  wr(8'hA5); frame(8'hA5, "8N c7");
    set_fmt(2'b10, 2'b00, 1'b0, 4'd8);  wr(8'h53); frame(8'h53, "7E c8");
    set_fmt(2'b01, 2'b00, 1'b1, 4'd15); wr(8'hFB); frame(8'hFB, "6O c15");
    set_fmt(2'b11, 2'b01, 1'b1, 4'd0);  wr(8'h00); frame(8'h00, "8 force1 c0");
    set_fmt(2'b11, 2'b01, 1'b0, 4'd3);  wr(8'hFF); frame(8'hFF, "8 force0 c3");
    set_fmt(2'b11, 2'b11, 1'b1, 4'd7);  wr(8'h81); frame(8'h81, "8 mode11 nopar");
  endtask

  task automatic t_five_bit();
    set_fmt(2'b00, 2'b10, 1'b0, 4'd0); wr(8'hF5); frame(8'hF5, "R5 5N c0");
    set_fmt(2'b00, 2'b10, 1'b0, 4'd7); wr(8'h0A); frame(8'h0A, "R5 5N c7");
    set_fmt(2'b00, 2'b00, 1'b1, 4'd8); wr(8'h13); frame(8'h13, "R5 5O c8");
  endtask

  task automatic t_back_to_back();
    set_fmt(2'b11, 2'b10, 1'b0, 4'd2);
    wr(8'h3C);
    fork
      begin frame(8'h3C, "R6 first"); frame(8'hC3, "R6 second"); end
      begin
        @(negedge clk);
        chk(tx_rdy === 1'b1, "R6 rdy after take", int'(tx_rdy), 1);
        wr(8'hC3);
        chk(tx_rdy === 1'b0, "R6 rdy while held", int'(tx_rdy), 0);
        chk(tx_emt === 1'b0, "R7 emt while held", int'(tx_emt), 0);
      end
    join
    chk(tx_emt === 1'b1, "R7 emt after last", int'(tx_emt), 1);
  endtask

  task automatic t_ignored_writes();
    int starts = 0;
    set_fmt(2'b11, 2'b10, 1'b0, 4'd7);
    wr(8'h11);
    fork
      begin frame(8'h11, "R8 A"); frame(8'h22, "R8 B kept"); end
      begin @(negedge clk); wr(8'h22); wr(8'h77); end
    join
    for (int i = 0; i < 60; i++) begin
      if (txd !== 1'b1) starts++;
      @(negedge clk);
    end
    chk(starts == 0, "R8 full write dropped", starts, 0);
    pulse(1);
    wr(8'h55);
    starts = 0;
    for (int i = 0; i < 60; i++) begin
      if (txd !== 1'b1 || tx_emt !== 1'b1) starts++;
      @(negedge clk);
    end
    chk(starts == 0, "R8 off write dropped", starts, 0);
    chk(tx_rdy === 1'b0, "R8 rdy while off", int'(tx_rdy), 0);
    pulse(0);
  endtask

  task automatic t_disable_drains();
    set_fmt(2'b10, 2'b00, 1'b0, 4'd9);
    wr(8'h6E);
    fork
      begin frame(8'h6E, "R9 current"); frame(8'h29, "R9 held"); end
      begin @(negedge clk); wr(8'h29); pulse(1); end
    join
    chk(tx_emt === 1'b1, "R9 empty after drain", int'(tx_emt), 1);
    chk(tx_rdy === 1'b0, "R9 rdy off", int'(tx_rdy), 0);
    pulse(0);
  endtask

  task automatic t_cts();
    int moved = 0;
    set_fmt(2'b11, 2'b10, 1'b0, 4'd7);
    cfg_cts_gate = 1'b1; cts_ok = 1'b0;
    wr(8'h9A);
    for (int i = 0; i < 50; i++) begin
      if (txd !== 1'b1) moved++;
      @(negedge clk);
    end
    chk(moved == 0, "R10 held off", moved, 0);
    chk(tx_emt === 1'b0, "R10 emt while waiting", int'(tx_emt), 0);
    cts_ok = 1'b1;
    frame(8'h9A, "R10 released");
    wr(8'h4D);
    fork
      frame(8'h4D, "R10 finishes");
      begin repeat (40) @(negedge clk); cts_ok = 1'b0; end
    join
    cts_ok = 1'b1; cfg_cts_gate = 1'b0;
  endtask

  task automatic t_rts();
    set_fmt(2'b11, 2'b10, 1'b0, 4'd7);
    pulse(2);
    chk(rts_o === 1'b1, "R11 set", int'(rts_o), 1);
    cfg_rts_auto = 1'b1;
    wr(8'h5A); frame(8'h5A, "R11 auto frame");
    chk(rts_o === 1'b1, "R11 still set at emt rise", int'(rts_o), 1);
    @(negedge clk);
    chk(rts_o === 1'b0, "R11 auto drop", int'(rts_o), 0);
    cfg_rts_auto = 1'b0;
    pulse(2);
    wr(8'hA5); frame(8'hA5, "R11 manual frame");
    repeat (3) @(negedge clk);
    chk(rts_o === 1'b1, "R11 kept without auto", int'(rts_o), 1);
    pulse(3);
    chk(rts_o === 1'b0, "R11 clear cmd", int'(rts_o), 0);
  endtask

  task automatic t_slow_tick();
    int lo = 0;
    int hi = 0;
    int guard = 0;
    set_fmt(2'b11, 2'b10, 1'b0, 4'd7);
    tp = 3;
    repeat (4) @(negedge clk);
    wr(8'hFF);
    while (txd !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
    while (txd === 1'b0 && lo < 200) begin lo++; @(negedge clk); end
    chk(lo >= 46 && lo <= 48, "R1 start at slow tick", lo, 47);
    while (txd === 1'b1 && tx_emt === 1'b0 && hi < 1000) begin hi++; @(negedge clk); end
    chk(hi == 432, "R1 data+stop at slow tick", hi, 432);
    tp = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_cmds();
    t_formats();
    t_five_bit();
    t_back_to_back();
    t_ignored_writes();
    t_disable_drains();
    t_cts();
    t_rts();
    t_slow_tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule